// File: doc/BRIEF.md
# Target Address and Insertion Pre-Check

This block screens an EPROM read or program request before the controller starts it. It raises two status flags, and the controller samples both before it lets an operation go ahead. The range flag covers the requested 12-bit target address. It goes high when that address lies beyond the 1 KB array of the target part, which holds locations 0 to 1023.

The insertion flag tells the controller whether a target part is fitted and fitted the right way round. The controller first sends a clear strobe, which zeroes a pulse counter. It then resets the target part. A good part then runs through every location of its blank program memory and gives one address-latch pulse per location. Those pulses come in from outside the clock domain. They pass through a synchroniser and an edge detector and are then counted. When the controller signals that the check window has ended, the block compares the count with the array size. If the count is short, the insertion flag is set, and it stays set until the next clear strobe.

Top module: `tgtchk_precheck`

## Requirements
- R1: While reset is asserted, and after it is released, both `addr_range_err` and `orient_err` are 0 until a stimulus sets them.
- R2: One clock after `tgt_addr` is applied, `addr_range_err` is 1 if the address is 1024 or above, which means bit 10 or bit 11 is set. It is 0 for addresses 0 to 1023.
- R3: Each rising edge of `latch_pulse` adds one to the count. This holds when the input stays high and stays low for at least 2 clocks each. A level held high for many clocks counts once.
- R4: On a clock where `window_done` is 1, `orient_err` becomes 1 if fewer than 1024 pulses have been counted since the last clear. For example, 0 pulses or 1023 pulses set the flag.
- R5: The count saturates at 1024. Exactly 1024 pulses, or any larger number, leaves `orient_err` at 0 when `window_done` is asserted.
- R6: `orient_err` changes only on a clock with `window_done` or `chk_clear` high. Pulses alone never change it.
- R7: Once `orient_err` is set, it stays set through further pulses and further `window_done` clocks, until the next `chk_clear`.
- R8: On the clock after `chk_clear` is 1, the count is zero and `orient_err` is 0. If `chk_clear` and `window_done` are high in the same clock, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tgt_addr | input | 12 | Target address of the pending operation |
| chk_clear | input | 1 | One-clock strobe that zeroes the pulse count and clears `orient_err` |
| latch_pulse | input | 1 | Address-latch pulse from the target part, asynchronous to `clk` |
| window_done | input | 1 | The check window has ended, so evaluate the count |
| addr_range_err | output | 1 | The address is outside the 1024-location array |
| orient_err | output | 1 | Too few latch pulses were seen, so the part is missing or reversed |

## Verification
`addr_range_err` is due one clock after a new address is applied. The bench drives the address on a falling edge and checks the flag on the next falling edge. A latch pulse reaches the counter two clocks after the edge that first samples it, so the bench waits six clocks after the last pulse before it raises `window_done`. The strobes `window_done` and `chk_clear` each act on the single rising edge inside their one-clock window. The bench checks `orient_err` on the falling edge just after that window, and it also checks the flag before each done strobe to show that pulses alone never change it.

// File: rtl/tgtchk_pkg.sv
package tgtchk_pkg;
  // Default geometry of the target part
  localparam int unsigned DEF_ADDR_W    = 12;
  localparam int unsigned DEF_DEV_DEPTH = 1024;
  localparam int unsigned DEF_SYNC_LEN  = 2;

  // Width needed to hold values 0..limit inclusive
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // True when depth is a power of two
  function automatic bit is_pow2(input int unsigned depth);
    return (depth != 0) && ((depth & (depth - 1)) == 0);
  endfunction
endpackage

// File: rtl/tgtchk_rst_sync.sv
module tgtchk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tgtchk_edge_sync.sv
module tgtchk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // Synchroniser chain, one flop per stage
  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = async_in;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_comb begin
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R3: one edge produces a single-cycle step
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tgtchk_pulse_count.sv
module tgtchk_pulse_count #(
  parameter int unsigned LIMIT = 1024,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_limit;

  assign at_limit = (cnt_q >= LIMIT_C);

  // Clock enable: a clear or a step that still has headroom
  always_comb begin
    cnt_en = clear_i | (step_i & ~at_limit);
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign full_o  = at_limit;

  // R5: the counter never passes the pass threshold
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LIMIT_C);
  // R8: a clear leaves the count at zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));
  // R3: a step below the limit adds exactly one
  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear_i && step_i && (count_o < LIMIT_C)) |=> (count_o == $past(count_o) + CNT_W'(1)));
  // R5: a step at the limit changes nothing
  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear_i && (count_o == LIMIT_C)) |=> (count_o == LIMIT_C));
endmodule

// File: rtl/tgtchk_addr_range.sv
module tgtchk_addr_range #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DEV_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              err_o
);
  import tgtchk_pkg::*;

  localparam int unsigned IDX_W = $clog2(DEV_DEPTH);

  logic out_of_range;
  logic err_q;

  // Power-of-two array: any bit above the index field flags it.
  // Otherwise a magnitude compare is needed.
  generate
    if (is_pow2(DEV_DEPTH) && (IDX_W < ADDR_W)) begin : g_upper_bits
      always_comb out_of_range = |addr_i[ADDR_W-1:IDX_W];
    end else begin : g_compare
      always_comb out_of_range = ({1'b0, addr_i} >= (ADDR_W+1)'(DEV_DEPTH));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= out_of_range;
  end

  assign err_o = err_q;

  // R2: the flag tracks the previous address against the array size
  a_r2_range_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(addr_i) >= ADDR_W'(DEV_DEPTH)) |-> err_o);
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(addr_i) < ADDR_W'(DEV_DEPTH)) |-> !err_o);
endmodule

// File: rtl/tgtchk_precheck.sv
module tgtchk_precheck #(
  parameter int unsigned ADDR_W    = tgtchk_pkg::DEF_ADDR_W,
  parameter int unsigned DEV_DEPTH = tgtchk_pkg::DEF_DEV_DEPTH,
  parameter int unsigned SYNC_LEN  = tgtchk_pkg::DEF_SYNC_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              chk_clear,
  input  logic              latch_pulse,
  input  logic              window_done,
  output logic              addr_range_err,
  output logic              orient_err
);
  import tgtchk_pkg::*;

  localparam int unsigned CNT_W = cnt_width(DEV_DEPTH);

  logic             rst_sync_n;
  logic             pulse_rise;
  logic [CNT_W-1:0] pulse_cnt;
  logic             cnt_full;
  logic             orient_q;
  logic             orient_d;
  logic             orient_en;

  tgtchk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tgtchk_addr_range #(.ADDR_W(ADDR_W), .DEV_DEPTH(DEV_DEPTH)) u_range (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .addr_i (tgt_addr),
    .err_o  (addr_range_err)
  );

  tgtchk_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .async_in (latch_pulse),
    .rise_o   (pulse_rise)
  );

  tgtchk_pulse_count #(.LIMIT(DEV_DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .clear_i (chk_clear),
    .step_i  (pulse_rise),
    .count_o (pulse_cnt),
    .full_o  (cnt_full)
  );

  // Sticky insertion flag: set on a short window, cleared only by the strobe
  always_comb begin
    orient_en = chk_clear | window_done;
    if (chk_clear) orient_d = 1'b0;
    else           orient_d = orient_q | ~cnt_full;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    orient_q <= 1'b0;
    else if (orient_en) orient_q <= orient_d;
  end

  assign orient_err = orient_q;

  // R6: without a strobe the flag holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!window_done && !chk_clear) |=> $stable(orient_err));
  // R7: a set flag survives everything but a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (orient_err && !chk_clear) |=> orient_err);
  // R8: a clear always drops the flag
  a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_clear |=> !orient_err);
  // R4: a short count at done raises the flag
  a_r4_short_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (window_done && !chk_clear && (pulse_cnt < CNT_W'(DEV_DEPTH))) |=> orient_err);
  // R1: the flags are low while reset is held
  always_comb begin
    if (!rst_sync_n) begin
      a_r1_reset_low: assert (!orient_err && !addr_range_err);
    end
  end
endmodule

// File: tb/tb_tgtchk_precheck.sv
module tb_tgtchk_precheck;
  logic        clk;
  logic        rst_n;
  logic [11:0] tgt_addr;
  logic        chk_clear;
  logic        latch_pulse;
  logic        window_done;
  logic        addr_range_err;
  logic        orient_err;

  int unsigned checks   = 0;
  int unsigned failures = 0;
  bit          done_flag = 0;

  tgtchk_precheck dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .tgt_addr       (tgt_addr),
    .chk_clear      (chk_clear),
    .latch_pulse    (latch_pulse),
    .window_done    (window_done),
    .addr_range_err (addr_range_err),
    .orient_err     (orient_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_range(input logic [11:0] a);
    return (a > 12'd1023);
  endfunction

  function automatic logic exp_orient(input int unsigned pulses);
    return (pulses < 1024);
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic check_addr(input logic [11:0] a);
    @(negedge clk) tgt_addr = a;
    @(negedge clk);
    chk("R2", addr_range_err, exp_range(a));
  endtask

  task automatic give_pulses(input int unsigned n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) latch_pulse = 1'b1;
      @(negedge clk);
      @(negedge clk) latch_pulse = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic long_pulse();
    @(negedge clk) latch_pulse = 1'b1;
    repeat (30) @(negedge clk);
    latch_pulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe_clear();
    @(negedge clk) chk_clear = 1'b1;
    @(negedge clk) chk_clear = 1'b0;
  endtask

  task automatic strobe_done();
    repeat (6) @(negedge clk);
    window_done = 1'b1;
    @(negedge clk) window_done = 1'b0;
  endtask

  task automatic window(input int unsigned n, input string req);
    strobe_clear();
    chk("R8", orient_err, 1'b0);
    give_pulses(n);
    repeat (6) @(negedge clk);
    chk("R6", orient_err, 1'b0);
    strobe_done();
    chk(req, orient_err, exp_orient(n));
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy  = $urandom(32'd4321);
    rst_n       = 1'b0;
    tgt_addr    = 12'd0;
    chk_clear   = 1'b0;
    latch_pulse = 1'b0;
    window_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", addr_range_err, 1'b0);
    chk("R1", orient_err, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", addr_range_err, 1'b0);
    chk("R1", orient_err, 1'b0);

    // R2 directed corners then random addresses
    check_addr(12'd0);
    check_addr(12'd1023);
    check_addr(12'd1024);
    check_addr(12'd2047);
    check_addr(12'd2048);
    check_addr(12'd4095);
    check_addr(12'd512);
    for (int i = 0; i < 24; i++) check_addr(12'($urandom));

    // R4 / R5 boundary windows
    window(0, "R4");
    window(1023, "R4");
    window(1024, "R5");
    window(1100, "R5");

    // R3: a long level counts once -> 1022 + 1 long = 1023, short
    strobe_clear();
    give_pulses(1022);
    long_pulse();
    strobe_done();
    chk("R3", orient_err, 1'b1);
    // R3: 1023 + 1 long = 1024, pass
    strobe_clear();
    give_pulses(1023);
    long_pulse();
    strobe_done();
    chk("R3", orient_err, 1'b0);

    // R7: flag set by a short window survives later pulses and done
    strobe_clear();
    give_pulses(1000);
    strobe_done();
    chk("R4", orient_err, 1'b1);
    give_pulses(40);
    repeat (6) @(negedge clk);
    chk("R7", orient_err, 1'b1);
    strobe_done();
    chk("R7", orient_err, 1'b1);
    strobe_clear();
    chk("R8", orient_err, 1'b0);

    // R8: clear and done in the same clock, clear wins
    @(negedge clk) begin chk_clear = 1'b1; window_done = 1'b1; end
    @(negedge clk) begin chk_clear = 1'b0; window_done = 1'b0; end
    chk("R8", orient_err, 1'b0);
    // R8: clear zeroes a full count, next done sees zero and fails
    strobe_done();
    chk("R8", orient_err, 1'b1);

    // Random windows near the threshold
    for (int i = 0; i < 3; i++) begin
      int unsigned n;
      n = 1010 + ($urandom % 30);
      window(n, (n < 1024) ? "R4" : "R5");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule